// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block turns a reference clock into the timing pulses a serial receiver and transmitter need. A programmable divisor with a 16-bit integer part and a 4-bit fractional part sets the period of an oversampling tick. The integer part is loaded from two byte-wide inputs. The fraction is produced by lengthening some tick periods by one reference cycle. Those longer periods are spread evenly over every run of 16 ticks, so the average period is the integer part plus the fraction divided by 16.

A second output, the bit strobe, marks the line bit rate. It fires on every 16th, 8th or 4th tick, as a 2-bit rate mode selects. With the same divisor, the line rate is therefore 1x, 2x or 4x the programmed rate. A new divisor, fraction or mode takes effect at the next tick boundary. While the enable is low, the counters are held cleared and the settings are copied through continuously.

Top module: `frac_baud_gen`

## Requirements
- R1: While `srst` is high, and in every cycle that follows a cycle with `en` low, `sample_tick` and `bit_strobe` are 0.
- R2: With a fraction of 0, consecutive `sample_tick` pulses are exactly DIV reference cycles apart, and the first pulse comes DIV cycles after the first enabled cycle.
- R3: With fraction F, tick period k lasts DIV+1 cycles when a 4-bit accumulator (cleared on enable, adding F at the end of each period) carries on the add for that period, and DIV cycles otherwise. Any 16 consecutive periods therefore hold exactly F lengthened ones.
- R4: DIV is `div_hi` in bits 15:8 and `div_lo` in bits 7:0.
- R5: A `div_lo` of zero is used as 1, so {0,0} gives DIV=1 and {1,0} gives DIV=257.
- R6: `rate_mode` 00 fires `bit_strobe` on every 16th tick, 01 on every 8th and 10 on every 4th; 11 behaves like 10. Ticks are counted from 1 after enable.
- R7: `bit_strobe` is a single-cycle pulse that is high only in a cycle where `sample_tick` is high.
- R8: A change of the divisor, fraction or mode inputs during a tick period does not alter that period. It applies from the period after it.
- R9: With DIV=9 and F=5, 16 consecutive periods from enable total 149 reference cycles, which is an average of 9.3125.
- R10: Dropping and raising `en` restarts the period counter, the fractional accumulator and the strobe count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| srst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low holds counters cleared |
| div_hi | input | 8 | Integer divisor, upper byte |
| div_lo | input | 8 | Integer divisor, lower byte (0 acts as 1) |
| frac | input | 4 | Fractional divisor in sixteenths |
| rate_mode | input | 2 | Oversampling select: 00 16x, 01 8x, 10/11 4x |
| sample_tick | output | 1 | One-cycle oversampling tick |
| bit_strobe | output | 1 | One-cycle pulse at the line bit rate |

## Verification
The bench builds the block with its default widths: a 16-bit integer divisor and a 4-bit fraction. This gives a 16-period window for the fractional pattern. It also lets a divisor whose high byte is nonzero (257, 258) be timed tick by tick in a short run. Every fractional period is compared against an accumulator model over two full windows. The strobe position is checked for all four mode codes. Divisor changes are timed against the tick boundary, together with the zero-low-byte clamp and restart after disable.

// File: rtl/frac_brg_pkg.sv
package frac_brg_pkg;

    // Oversampling select; the spare code repeats the 4x setting.
    typedef enum logic [1:0] {
        RM_X16    = 2'b00,
        RM_X8     = 2'b01,
        RM_X4     = 2'b10,
        RM_X4_ALT = 2'b11
    } rate_mode_e;

    localparam int OS_W = 4;

    function automatic logic [OS_W-1:0] os_last(rate_mode_e m);
        case (m)
            RM_X16:  return OS_W'(15);
            RM_X8:   return OS_W'(7);
            default: return OS_W'(3);
        endcase
    endfunction

endpackage

// File: rtl/brg_cfg_shadow.sv
module brg_cfg_shadow
    import frac_brg_pkg::*;
#(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 4,
    localparam int BYTE_W = INT_W / 2
) (
    input  logic              clk,
    input  logic              load,
    input  logic [BYTE_W-1:0] div_hi,
    input  logic [BYTE_W-1:0] div_lo,
    input  logic [FRAC_W-1:0] frac_in,
    input  rate_mode_e        mode_in,
    output logic [INT_W-1:0]  div_act,
    output logic [FRAC_W-1:0] frac_act,
    output rate_mode_e        mode_act
);

    typedef struct packed {
        logic [INT_W-1:0]  div;
        logic [FRAC_W-1:0] frac;
        rate_mode_e        mode;
    } cfg_t;

    cfg_t              cfg_d, cfg_q;
    logic [BYTE_W-1:0] lo_fixed;

    always_comb begin
        // a zero low byte is never used as a divisor
        lo_fixed = (div_lo == '0) ? BYTE_W'(1) : div_lo;
        cfg_d    = cfg_q;
        if (load) begin
            cfg_d.div  = {div_hi, lo_fixed};
            cfg_d.frac = frac_in;
            cfg_d.mode = mode_in;
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    assign div_act  = cfg_q.div;
    assign frac_act = cfg_q.frac;
    assign mode_act = cfg_q.mode;

endmodule

// File: rtl/brg_period_gen.sv
module brg_period_gen #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 4,
    localparam int CNT_W = INT_W + 1
) (
    input  logic              clk,
    input  logic              srst,
    input  logic              en,
    input  logic [INT_W-1:0]  div_act,
    input  logic [FRAC_W-1:0] frac_act,
    output logic              period_end,
    output logic              tick
);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [FRAC_W-1:0] acc;
        logic              tick;
    } st_t;

    st_t              st_d, st_q;
    logic [FRAC_W:0]  acc_sum;
    logic [CNT_W-1:0] period_len;
    logic [CNT_W-1:0] last_cnt;

    always_comb begin
        // the carry out of the phase add stretches this period by one cycle
        acc_sum    = {1'b0, st_q.acc} + {1'b0, frac_act};
        period_len = {1'b0, div_act} + {{INT_W{1'b0}}, acc_sum[FRAC_W]};
        last_cnt   = period_len - CNT_W'(1);
        period_end = en && !srst && (st_q.cnt == last_cnt);

        st_d      = st_q;
        st_d.tick = period_end;
        if (srst || !en) begin
            st_d = '0;
        end else if (period_end) begin
            st_d.cnt = '0;
            st_d.acc = acc_sum[FRAC_W-1:0];
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign tick = st_q.tick;

endmodule

// File: rtl/brg_os_div.sv
module brg_os_div
    import frac_brg_pkg::*;
(
    input  logic       clk,
    input  logic       srst,
    input  logic       en,
    input  logic       period_end,
    input  rate_mode_e mode_act,
    output logic       strobe
);

    typedef struct packed {
        logic [OS_W-1:0] os;
        logic            strobe;
    } st_t;

    st_t             st_d, st_q;
    logic [OS_W-1:0] last_q;

    always_comb begin
        last_q      = os_last(mode_act);
        st_d        = st_q;
        st_d.strobe = 1'b0;
        if (srst || !en) begin
            st_d = '0;
        end else if (period_end) begin
            // ">=" lets a switch to a shorter ratio wrap on the next tick
            if (st_q.os >= last_q) begin
                st_d.os     = '0;
                st_d.strobe = 1'b1;
            end else begin
                st_d.os = st_q.os + OS_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign strobe = st_q.strobe;

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import frac_brg_pkg::*;
#(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 4,
    localparam int BYTE_W = INT_W / 2
) (
    input  logic              clk,
    input  logic              srst,
    input  logic              en,
    input  logic [BYTE_W-1:0] div_hi,
    input  logic [BYTE_W-1:0] div_lo,
    input  logic [FRAC_W-1:0] frac,
    input  logic [1:0]        rate_mode,
    output logic              sample_tick,
    output logic              bit_strobe
);

    logic              period_end;
    logic              cfg_load;
    logic [INT_W-1:0]  div_act;
    logic [FRAC_W-1:0] frac_act;
    rate_mode_e        mode_in;
    rate_mode_e        mode_act;

    assign mode_in  = rate_mode_e'(rate_mode);
    // settings track the inputs while idle and re-latch on each tick boundary
    assign cfg_load = srst || !en || period_end;

    brg_cfg_shadow #(
        .INT_W (INT_W),
        .FRAC_W(FRAC_W)
    ) u_cfg (
        .clk     (clk),
        .load    (cfg_load),
        .div_hi  (div_hi),
        .div_lo  (div_lo),
        .frac_in (frac),
        .mode_in (mode_in),
        .div_act (div_act),
        .frac_act(frac_act),
        .mode_act(mode_act)
    );

    brg_period_gen #(
        .INT_W (INT_W),
        .FRAC_W(FRAC_W)
    ) u_period (
        .clk       (clk),
        .srst      (srst),
        .en        (en),
        .div_act   (div_act),
        .frac_act  (frac_act),
        .period_end(period_end),
        .tick      (sample_tick)
    );

    brg_os_div u_os (
        .clk       (clk),
        .srst      (srst),
        .en        (en),
        .period_end(period_end),
        .mode_act  (mode_act),
        .strobe    (bit_strobe)
    );

endmodule

// File: rtl/frac_baud_gen_chk.sv
module frac_baud_gen_chk (
    input logic clk,
    input logic srst,
    input logic en,
    input logic sample_tick,
    input logic bit_strobe
);

    logic [4:0] ticks_since;

    // ticks seen since the last strobe or restart, saturating
    always_ff @(posedge clk) begin
        if (srst || !en) begin
            ticks_since <= '0;
        end else if (sample_tick) begin
            if (bit_strobe)
                ticks_since <= '0;
            else if (ticks_since != 5'd31)
                ticks_since <= ticks_since + 5'd1;
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (srst)
        $fell(srst) |-> (!sample_tick && !bit_strobe));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (srst)
        !en |=> (!sample_tick && !bit_strobe));

    a_r7_strobe_on_tick: assert property (@(posedge clk) disable iff (srst)
        bit_strobe |-> sample_tick);

    a_r7_strobe_single: assert property (@(posedge clk) disable iff (srst)
        bit_strobe |=> !bit_strobe);

    a_r6_strobe_spacing: assert property (@(posedge clk) disable iff (srst)
        (bit_strobe && en) |-> (ticks_since >= 5'd3));

endmodule

bind frac_baud_gen frac_baud_gen_chk u_chk (
    .clk        (clk),
    .srst       (srst),
    .en         (en),
    .sample_tick(sample_tick),
    .bit_strobe (bit_strobe)
);

// File: tb/tb_frac_baud_gen.sv
module tb_frac_baud_gen;

    logic       clk = 1'b0;
    logic       srst;
    logic       en;
    logic [7:0] div_hi;
    logic [7:0] div_lo;
    logic [3:0] frac;
    logic [1:0] rate_mode;
    logic       sample_tick;
    logic       bit_strobe;

    int n_checks = 0;
    int n_fail   = 0;
    int t_time[0:63];
    bit t_strb[0:63];
    int n_ticks;
    int stray;

    always #5 clk = ~clk;

    frac_baud_gen dut (
        .clk        (clk),
        .srst       (srst),
        .en         (en),
        .div_hi     (div_hi),
        .div_lo     (div_lo),
        .frac       (frac),
        .rate_mode  (rate_mode),
        .sample_tick(sample_tick),
        .bit_strobe (bit_strobe)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int iv(int k);
        return (k == 0) ? t_time[0] : t_time[k] - t_time[k-1];
    endfunction

    // load settings while idle, then enable on a falling edge
    task automatic start(logic [7:0] hi, logic [7:0] lo, logic [3:0] fr, logic [1:0] md);
        @(negedge clk);
        en = 1'b0; div_hi = hi; div_lo = lo; frac = fr; rate_mode = md;
        repeat (2) @(negedge clk);
        en = 1'b1;
    endtask

    task automatic collect(int want, int max_cyc, int chg_at, logic [7:0] nhi, logic [7:0] nlo);
        int cyc = 0;
        n_ticks = 0;
        stray   = 0;
        while (n_ticks < want && cyc < max_cyc) begin
            @(negedge clk);
            cyc++;
            if (bit_strobe && !sample_tick) stray++;
            if (sample_tick) begin
                t_time[n_ticks] = cyc;
                t_strb[n_ticks] = bit_strobe;
                if (n_ticks == chg_at) begin
                    div_hi = nhi;
                    div_lo = nlo;
                end
                n_ticks++;
            end
        end
    endtask

    task automatic t_reset();
        srst = 1'b1; en = 1'b1; div_hi = 8'd0; div_lo = 8'd1; frac = 4'd0; rate_mode = 2'b10;
        repeat (4) @(negedge clk);
        chk("R1", "tick in reset", int'(sample_tick), 0);
        chk("R1", "strobe in reset", int'(bit_strobe), 0);
        srst = 1'b0;
    endtask

    task automatic t_integer();
        start(8'd0, 8'd5, 4'd0, 2'b00);
        collect(20, 500, -1, 8'd0, 8'd0);
        chk("R2", "tick count", n_ticks, 20);
        for (int k = 0; k < 20; k++) chk("R2", "period", iv(k), 5);
    endtask

    task automatic t_fraction();
        int acc = 0;
        int nst = 0;
        int s;
        start(8'd0, 8'd9, 4'd5, 2'b00);
        collect(32, 800, -1, 8'd0, 8'd0);
        chk("R3", "tick count", n_ticks, 32);
        for (int k = 0; k < 32; k++) begin
            s = ((acc + 5) >= 16) ? 1 : 0;
            acc = (acc + 5) % 16;
            chk("R3", "fractional period", iv(k), 9 + s);
        end
        for (int k = 7; k < 23; k++) if (iv(k) == 10) nst++;
        chk("R3", "stretched in window", nst, 5);
        chk("R9", "16 periods total", t_time[15], 149);
    endtask

    task automatic t_bytes();
        start(8'd1, 8'd2, 4'd0, 2'b00);
        collect(3, 2000, -1, 8'd0, 8'd0);
        for (int k = 0; k < 3; k++) chk("R4", "two-byte period", iv(k), 258);
    endtask

    task automatic t_lo_zero();
        start(8'd0, 8'd0, 4'd0, 2'b00);
        collect(8, 100, -1, 8'd0, 8'd0);
        for (int k = 0; k < 8; k++) chk("R5", "zero low byte as 1", iv(k), 1);
        start(8'd1, 8'd0, 4'd0, 2'b00);
        collect(2, 1000, -1, 8'd0, 8'd0);
        for (int k = 0; k < 2; k++) chk("R5", "high byte with zero low", iv(k), 257);
    endtask

    task automatic t_modes();
        int ratio;
        for (int md = 0; md < 4; md++) begin
            ratio = (md == 0) ? 16 : (md == 1) ? 8 : 4;
            start(8'd0, 8'd2, 4'd0, 2'(md));
            collect(33, 200, -1, 8'd0, 8'd0);
            for (int k = 0; k < 33; k++)
                chk("R6", "strobe position", int'(t_strb[k]), ((k + 1) % ratio == 0) ? 1 : 0);
            chk("R7", "strobe without tick", stray, 0);
            chk("R7", "tick spacing", iv(5), 2);
        end
    endtask

    task automatic t_change();
        start(8'd0, 8'd4, 4'd0, 2'b00);
        collect(6, 200, 1, 8'd0, 8'd7);
        chk("R8", "period before change", iv(1), 4);
        chk("R8", "period in progress", iv(2), 4);
        chk("R8", "first new period", iv(3), 7);
        chk("R8", "later new period", iv(5), 7);
    endtask

    task automatic t_restart();
        int acc;
        int s;
        start(8'd0, 8'd3, 4'd5, 2'b10);
        collect(5, 200, -1, 8'd0, 8'd0);
        @(negedge clk);
        en = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R1", "tick while disabled", int'(sample_tick), 0);
        end
        start(8'd0, 8'd3, 4'd5, 2'b10);
        collect(8, 200, -1, 8'd0, 8'd0);
        acc = 0;
        for (int k = 0; k < 8; k++) begin
            s = ((acc + 5) >= 16) ? 1 : 0;
            acc = (acc + 5) % 16;
            chk("R10", "period after restart", iv(k), 3 + s);
            chk("R10", "strobe after restart", int'(t_strb[k]), ((k + 1) % 4 == 0) ? 1 : 0);
        end
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_integer();
        t_fraction();
        t_bytes();
        t_lo_zero();
        t_modes();
        t_change();
        t_restart();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule